// File: doc/BRIEF.md
# Two-Wire Slave Port for a Byte Register Space

This block lets an external two-wire (I2C) master read and write a 256-byte register and RAM space one byte at a time. It runs entirely on a fast system clock. It samples the already-filtered SCL and SDA levels, synchronises them and finds their edges, so no flop is clocked by SCL. It answers a 7-bit device address whose six upper bits are fixed at 101000 and whose lowest bit follows a strap pin.

Inside, an 8-bit word pointer selects the location for each byte. The first byte that follows a write-addressed START loads the pointer. Every later byte, read or written, uses the pointer and then advances it by one. The master can also set the pointer, issue a repeated START with a read address and stream data out, or simply read from wherever the pointer was left.

The register space is reached through a plain strobe port. A write shows up as a one-cycle write strobe carrying the address and data. A read shows up as a one-cycle read strobe, and the read data input is sampled in that same cycle.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The slave responds to the address byte {1,0,1,0,0,0,a0_i,R/W}, sent MSB first, by asserting sda_pull_o during the ninth SCL clock. The R/W bit is 1 for read and 0 for write.
- R2: When the address does not match, the slave does not acknowledge. It then makes no register access and does not drive SDA until the next START.
- R3: In a write transfer the first byte after the address loads the word pointer, and the slave acknowledges that byte.
- R4: Each later byte of a write transfer is acknowledged. It is written at the pointer with one reg_we_o pulse, and the pointer then increments.
- R5: In a read transfer the slave issues one reg_re_o pulse per byte, samples reg_rdata_i in that cycle and shifts the byte out MSB first. The pointer increments after each byte, and SDA changes only while SCL is low.
- R6: A repeated START is accepted in any state and restarts the address phase while keeping the pointer.
- R7: The pointer wraps from 0xFF to 0x00, both when writing and when reading.
- R8: After the master does not acknowledge a read byte, the slave releases SDA and stays off the bus until the next START.
- R9: A STOP returns the slave to idle, and the pointer keeps its value for the next transfer.
- R10: Reset leaves SDA released, both strobes low and the pointer at 0x00.
- R11: reg_we_o and reg_re_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| a0_i | input | 1 | Strap pin that sets address bit 0 |
| sda_pull_o | output | 1 | 1 = pull the open-drain SDA line low |
| reg_addr_o | output | 8 | Register address (the word pointer) |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, sampled while reg_re_o is high |

## Verification
The pointer wrap and a register access fall on the same SCL falling edge. That edge writes location 0xFF and, in the same cycle, takes the pointer to 0x00. The bench provokes this by loading the pointer with 0xFE and writing three bytes; it then checks that the third byte lands at 0x00. The same coincidence on the read side is provoked by pointing at 0xFF and reading two bytes, which must return the contents of 0xFF and then 0x00.

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter logic [5:0] DEV_HI = 6'b101000,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       a0_i,
  output logic       sda_pull_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_we_o,
  output logic       reg_re_o,
  input  logic [7:0] reg_rdata_i
);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_PTR, S_PTR_ACK, S_WR, S_WR_ACK, S_TX, S_MACK
  } st_t;

  logic [SYNC:0] scl_q, sda_q;
  st_t        st;
  logic [7:0] sh, ptr;
  logic [3:0] cnt;
  logic       rw, nack, pull;

  wire scl_s = scl_q[SYNC-1];
  wire scl_p = scl_q[SYNC];
  wire sda_s = sda_q[SYNC-1];
  wire sda_p = sda_q[SYNC];

  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  wire quiet    = ~start_c & ~stop_c;

  wire load = quiet & scl_fall &
              ((st == S_DEV_ACK && rw) || (st == S_MACK && !nack));

  assign reg_re_o    = load;
  assign reg_we_o    = quiet & scl_fall & (st == S_WR) & (cnt == 4'd8);
  assign reg_addr_o  = ptr;
  assign reg_wdata_o = sh;
  assign sda_pull_o  = pull;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC-1:0], scl_i};
      sda_q <= {sda_q[SYNC-1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sh   <= '0;
      ptr  <= '0;
      cnt  <= '0;
      rw   <= 1'b0;
      nack <= 1'b1;
      pull <= 1'b0;
    end else if (start_c) begin
      st   <= S_DEV;
      cnt  <= '0;
      pull <= 1'b0;
    end else if (stop_c) begin
      st   <= S_IDLE;
      pull <= 1'b0;
    end else if (scl_rise) begin
      if (st == S_DEV || st == S_PTR || st == S_WR) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (st == S_MACK) begin
        nack <= sda_s;
      end
    end else if (scl_fall) begin
      if (load) begin
        sh   <= reg_rdata_i;
        pull <= ~reg_rdata_i[7];
        ptr  <= ptr + 8'd1;
        cnt  <= 4'd1;
        st   <= S_TX;
      end else begin
        case (st)
          S_DEV: if (cnt == 4'd8) begin
            if (sh[7:1] == {DEV_HI, a0_i}) begin
              rw   <= sh[0];
              pull <= 1'b1;
              st   <= S_DEV_ACK;
            end else begin
              st <= S_IDLE;
            end
          end
          S_PTR: if (cnt == 4'd8) begin
            ptr  <= sh;
            pull <= 1'b1;
            st   <= S_PTR_ACK;
          end
          S_WR: if (cnt == 4'd8) begin
            ptr  <= ptr + 8'd1;
            pull <= 1'b1;
            st   <= S_WR_ACK;
          end
          S_DEV_ACK: begin
            pull <= 1'b0;
            cnt  <= '0;
            st   <= S_PTR;
          end
          S_PTR_ACK, S_WR_ACK: begin
            pull <= 1'b0;
            cnt  <= '0;
            st   <= S_WR;
          end
          S_TX: if (cnt == 4'd8) begin
            pull <= 1'b0;
            st   <= S_MACK;
          end else begin
            pull <= ~sh[6];
            sh   <= {sh[6:0], 1'b0};
            cnt  <= cnt + 4'd1;
          end
          S_MACK: st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module i2c_regfile_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_pull_o,
  input logic reg_we_o,
  input logic reg_re_o
);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));

  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R11
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re_o |=> !reg_re_o);

  // R4
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> sda_pull_o);

  // R5
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R10
  rst_release_chk: assert property (@(posedge clk)
    !rst_n |=> !sda_pull_o);

endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o)
);

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
  localparam int HALF = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, a0 = 1'b0;
  logic sda_pull, we, re;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] mem [256];
  int n_chk = 0, n_fail = 0, we_cnt = 0, re_cnt = 0;
  logic done = 1'b0;
  wire sda_bus = sda_m & ~sda_pull;

  always #5 clk = ~clk;

  i2c_regfile_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .a0_i(a0),
    .sda_pull_o(sda_pull), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  assign rdata = mem[addr];
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (we) we_cnt <= we_cnt + 1;
    if (re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic gap();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; gap(); scl_m = 1'b1; gap();
    sda_m = 1'b0; gap(); scl_m = 1'b0; gap();
  endtask

  task automatic bstop();
    sda_m = 1'b0; gap(); scl_m = 1'b1; gap(); sda_m = 1'b1; gap();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; gap(); scl_m = 1'b1; gap(); scl_m = 1'b0;
    end
    sda_m = 1'b1; gap(); scl_m = 1'b1; gap();
    ack = ~sda_bus;
    scl_m = 1'b0;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      gap(); scl_m = 1'b1; gap(); b[i] = sda_bus; scl_m = 1'b0;
    end
    sda_m = ~mack; gap(); scl_m = 1'b1; gap(); scl_m = 1'b0;
    gap(); sda_m = 1'b1;
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] d;
    chk("R10 pull", sda_pull, 0);
    chk("R10 strobes", {we, re}, 0);
    bstart(); wbyte(8'hA1, ack); rbyte(1'b0, d); bstop();
    chk("R1 read addr ack", ack, 1);
    chk("R10 pointer zero", d, 8'h5A);
  endtask

  task automatic t_write();
    logic a0k, a1, a2, a3, a4;
    bstart(); wbyte(8'hA0, a0k); wbyte(8'h10, a1);
    wbyte(8'h11, a2); wbyte(8'h22, a3); wbyte(8'h33, a4); bstop();
    chk("R1 write addr ack", a0k, 1);
    chk("R3 pointer byte ack", a1, 1);
    chk("R4 data acks", {a2, a3, a4}, 3'b111);
    chk("R4 mem", {mem[8'h10], mem[8'h11], mem[8'h12]}, 24'h112233);
    chk("R4 we count", we_cnt, 3);
  endtask

  task automatic t_combined();
    logic a, b, c; logic [7:0] d0, d1, d2; int r0;
    r0 = re_cnt;
    bstart(); wbyte(8'hA0, a); wbyte(8'h10, b);
    bstart(); wbyte(8'hA1, c);
    rbyte(1'b1, d0); rbyte(1'b1, d1); rbyte(1'b0, d2); bstop();
    chk("R6 repeated start ack", {a, b, c}, 3'b111);
    chk("R5 sequential read", {d0, d1, d2}, 24'h112233);
    chk("R11 one re per byte", re_cnt - r0, 3);
  endtask

  task automatic t_immediate();
    logic a; logic [7:0] d;
    bstart(); wbyte(8'hA1, a); rbyte(1'b0, d); bstop();
    chk("R9 pointer kept", d, 8'h13 ^ 8'h5A);
  endtask

  task automatic t_wrap();
    logic a, b, c, e, f, g; logic [7:0] d0, d1;
    bstart(); wbyte(8'hA0, a); wbyte(8'hFE, b);
    wbyte(8'h01, c); wbyte(8'h02, e); wbyte(8'h03, f); bstop();
    chk("R7 write wrap", {mem[8'hFE], mem[8'hFF], mem[8'h00]}, 24'h010203);
    bstart(); wbyte(8'hA0, a); wbyte(8'hFF, b);
    bstart(); wbyte(8'hA1, g); rbyte(1'b1, d0); rbyte(1'b0, d1); bstop();
    chk("R7 read wrap", {d0, d1}, 16'h0203);
  endtask

  task automatic t_mismatch();
    logic a, b; logic [7:0] d; int w0, r0;
    w0 = we_cnt; r0 = re_cnt;
    bstart(); wbyte(8'hA2, a); wbyte(8'h05, b); wbyte(8'hEE, b); bstop();
    chk("R2 no ack", a, 0);
    chk("R2 no ack data", b, 0);
    chk("R2 no access", (we_cnt - w0) + (re_cnt - r0), 0);
    chk("R2 mem kept", mem[8'h05], 8'h05 ^ 8'h5A);
    bstart(); wbyte(8'hA1, a); rbyte(1'b0, d); bstop();
    chk("R2 pointer kept", d, 8'h01 ^ 8'h5A);
  endtask

  task automatic t_a0();
    logic a, b, c;
    a0 = 1'b1; gap();
    bstart(); wbyte(8'hA2, a); wbyte(8'h80, b); wbyte(8'hC3, c); bstop();
    chk("R1 a0 high ack", {a, b, c}, 3'b111);
    chk("R1 a0 high write", mem[8'h80], 8'hC3);
    bstart(); wbyte(8'hA0, a); bstop();
    chk("R1 a0 mismatch", a, 0);
    a0 = 1'b0; gap();
  endtask

  task automatic t_nack();
    logic a; logic [7:0] d; int r0, pulls;
    bstart(); wbyte(8'hA1, a); rbyte(1'b0, d);
    r0 = re_cnt; pulls = 0;
    for (int i = 0; i < 9; i++) begin
      gap(); scl_m = 1'b1;
      for (int k = 0; k < HALF; k++) begin
        @(negedge clk); if (sda_pull) pulls++;
      end
      scl_m = 1'b0;
    end
    bstop();
    chk("R8 released", pulls, 0);
    chk("R8 no reads", re_cnt - r0, 0);
  endtask

  task automatic t_stop_mid();
    logic a, b, c; logic [7:0] d;
    bstart(); wbyte(8'hA0, a); wbyte(8'h40, b); wbyte(8'h77, c); bstop();
    bstart(); wbyte(8'hA1, a); rbyte(1'b0, d); bstop();
    chk("R9 stop then read", d, 8'h41 ^ 8'h5A);
    chk("R9 write landed", mem[8'h40], 8'h77);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write();
    t_combined();
    t_immediate();
    t_wrap();
    t_mismatch();
    t_a0();
    t_nack();
    t_stop_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule